// File: doc/BRIEF.md
# Internal Clock Frequency Selector

This block builds the system clock of a chip from its internal oscillators. It takes three free-running oscillator inputs and an optional multiplier clock. The high-frequency source runs at 16 MHz, the medium source at 500 kHz, the low source at 31 kHz, and the 4x multiplier clock at 32 MHz. A 4-bit frequency code is held in a register that software writes. The code picks a rate from 32 MHz down to 31 kHz. Each oscillator has its own binary postscaler, so the code chooses both the oscillator and the division factor.

Some rates can be reached from two oscillators. 500 kHz down to 125 kHz can come either from the 16 MHz source divided down or from the 500 kHz source. A code that keeps the same oscillator only retaps its postscaler. A code that moves to a different oscillator is lower in power but passes through a clean handover. In that handover the old clock is released on its low phase, and the new clock is enabled on its own low phase, so no short pulse reaches the output.

The 32 MHz path opens only when three things are true: the source field names the internal oscillator, the code asks for 8 MHz, and a multiplier enable is present. That enable can come from a software bit or from a configuration-level force. A second output reports which oscillator currently drives the clock.

Top module: `intclk_freq_sel`

## Requirements
- R1: After reset the code register holds 4'b0111. The output runs at 500 kHz taken directly from the medium source, and `activeSrc` reads 2'b01.
- R2: Code 4'b1111 outputs the 16 MHz source undivided, and `activeSrc` reads 2'b10.
- R3: Codes 4'b1110 down to 4'b1000 output the 16 MHz source divided by 2^(15-code), giving 8 MHz down to 125 kHz, with `activeSrc` 2'b10.
- R4: Code 4'b0111 outputs the medium source undivided. Codes 4'b0110 down to 4'b0011 divide it by 2^(7-code), giving 250 kHz down to 31.25 kHz. Code 4'b0010 also gives 31.25 kHz. In all of these `activeSrc` reads 2'b01.
- R5: Codes 4'b0000 and 4'b0001 output the 31 kHz low source undivided, with `activeSrc` 2'b00.
- R6: The 32 MHz multiplier clock is output, with `activeSrc` 2'b11, when `clkSrc` is 3'b100, the code is 4'b1110 and the software multiplier bit is 1.
- R7: While `cfgPllForce` is 1 and `clkSrc` is 3'b100, code 4'b1110 gives 32 MHz even with the software bit at 0, so plain 8 MHz cannot be reached. Other codes keep their normal rates.
- R8: If any multiplier condition is missing, code 4'b1110 gives 8 MHz from the high source. For example, `clkSrc` not 3'b100 with the software bit set still gives 8 MHz.
- R9: At most one clock candidate is enabled onto the output at any time. Handovers between candidates are break-before-make.
- R10: The code register and the software multiplier bit change only on a `clk` edge where `wrEn` is 1. Changing `wrSel` while `wrEn` is 0 has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and control clock |
| rstN | input | 1 | Asynchronous active-low reset for all domains |
| wrEn | input | 1 | Write strobe for the code register and multiplier bit |
| wrSel | input | 4 | Frequency code to write |
| wrPll | input | 1 | Software multiplier enable to write |
| cfgPllForce | input | 1 | Configuration-level multiplier enable |
| clkSrc | input | 3 | System-clock source field; 3'b100 means internal oscillator |
| hfClk | input | 1 | 16 MHz high-frequency oscillator |
| mfClk | input | 1 | 500 kHz medium-frequency oscillator |
| lfClk | input | 1 | 31 kHz low-frequency oscillator |
| pllClk | input | 1 | 32 MHz output of the 4x multiplier |
| sysClk | output | 1 | Selected system clock |
| activeSrc | output | 2 | Source of sysClk: 00 low, 01 medium, 10 high, 11 multiplier |

## Verification
The main function is tried by walking the code through every oscillator family and measuring the output period together with the source report. These cases cover:
- an undivided tap against a divided one within the same oscillator;
- a retap that keeps the oscillator against a move to another oscillator;
- two codes that share a rate, 4'b0011 and 4'b0010;
- the low-source codes 4'b0001 and 4'b0000.

The multiplier gate is tried with each condition taken away in turn: the source field, the software bit, and the force input. This tells a gate that checks all three apart from one that checks only some of them. A write attempt with the strobe held low is then used to show that the register ignores the data bus.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

  localparam int SEL_W    = 4;
  localparam int SRC_W    = 3;
  localparam int HF_TAPS  = 7;
  localparam int MF_TAPS  = 4;
  localparam int HF_TAP_W = $clog2(HF_TAPS);
  localparam int MF_TAP_W = $clog2(MF_TAPS);

  // clock candidates seen by the output switch
  localparam int C_LF     = 0;
  localparam int C_MF_RAW = 1;
  localparam int C_MF_DIV = 2;
  localparam int C_HF_RAW = 3;
  localparam int C_HF_DIV = 4;
  localparam int C_PLL    = 5;
  localparam int NUM_CAND = 6;

  localparam logic [SEL_W-1:0] SEL_RESET  = 4'b0111;
  localparam logic [SEL_W-1:0] SEL_HF_RAW = 4'b1111;
  localparam logic [SEL_W-1:0] SEL_PLL    = 4'b1110;
  localparam logic [SEL_W-1:0] SEL_HF_MIN = 4'b1000;
  localparam logic [SEL_W-1:0] SEL_MF_RAW = 4'b0111;
  localparam logic [SEL_W-1:0] SEL_MF_MIN = 4'b0011;
  localparam logic [SEL_W-1:0] SEL_MF_DUP = 4'b0010;
  localparam logic [SRC_W-1:0] SRC_INTOSC = 3'b100;

  typedef enum logic [1:0] {
    ID_LF  = 2'b00,
    ID_MF  = 2'b01,
    ID_HF  = 2'b10,
    ID_PLL = 2'b11
  } srcId_e;

  typedef struct packed {
    logic [NUM_CAND-1:0] pick;
    logic [HF_TAP_W-1:0] hfTap;
    logic [MF_TAP_W-1:0] mfTap;
    srcId_e              srcId;
  } selCtl_t;

endpackage

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
  import clksel_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic             wrPll,
  input  logic             cfgPllForce,
  input  logic [SRC_W-1:0] clkSrc,
  output selCtl_t          ctl
);

  localparam selCtl_t CTL_RESET = '{
    pick:  NUM_CAND'(1) << C_MF_RAW,
    hfTap: '0,
    mfTap: '0,
    srcId: ID_MF
  };

  logic [SEL_W-1:0] selReg;
  logic             pllReg;
  logic             pllGo;
  selCtl_t          ctlNext;

  // software-visible code register and multiplier bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= SEL_RESET;
      pllReg <= 1'b0;
    end else if (wrEn) begin
      selReg <= wrSel;
      pllReg <= wrPll;
    end
  end

  // all three gate conditions for the multiplier path
  assign pllGo = (clkSrc == SRC_INTOSC) && (selReg == SEL_PLL) &&
                 (pllReg || cfgPllForce);

  always_comb begin
    ctlNext       = '0;
    ctlNext.srcId = ID_LF;
    if (pllGo) begin
      ctlNext.pick[C_PLL] = 1'b1;
      ctlNext.srcId       = ID_PLL;
    end else if (selReg == SEL_HF_RAW) begin
      ctlNext.pick[C_HF_RAW] = 1'b1;
      ctlNext.srcId          = ID_HF;
    end else if (selReg >= SEL_HF_MIN) begin
      ctlNext.pick[C_HF_DIV] = 1'b1;
      ctlNext.hfTap          = HF_TAP_W'(SEL_PLL - selReg);
      ctlNext.srcId          = ID_HF;
    end else if (selReg == SEL_MF_RAW) begin
      ctlNext.pick[C_MF_RAW] = 1'b1;
      ctlNext.srcId          = ID_MF;
    end else if (selReg >= SEL_MF_DUP) begin
      ctlNext.pick[C_MF_DIV] = 1'b1;
      ctlNext.srcId          = ID_MF;
      if (selReg >= SEL_MF_MIN)
        ctlNext.mfTap = MF_TAP_W'(SEL_MF_RAW - SEL_W'(1) - selReg);
      else
        ctlNext.mfTap = MF_TAP_W'(MF_TAPS - 1);
    end else begin
      ctlNext.pick[C_LF] = 1'b1;
      ctlNext.srcId      = ID_LF;
    end
  end

  // registered so the request lines crossing into oscillator domains are clean
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctl <= CTL_RESET;
    else       ctl <= ctlNext;
  end

  // R10: register holds without a write strobe
  p_hold_sel_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(selReg) && $stable(pllReg));

  // R6: multiplier picked only with internal source and 8 MHz code
  p_pll_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pick[C_PLL] |-> ($past(clkSrc) == SRC_INTOSC) && ($past(selReg) == SEL_PLL));

  // R7: the force input alone opens the multiplier path
  p_force_pll_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cfgPllForce) && $past(clkSrc) == SRC_INTOSC && $past(selReg) == SEL_PLL)
      |-> ctl.pick[C_PLL]);

  // R9: exactly one candidate requested
  p_one_pick_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(ctl.pick));

endmodule

// File: rtl/clksel_postscaler.sv
module clksel_postscaler #(
  parameter int TAPS  = 7,
  parameter int TAP_W = 3
) (
  input  logic             srcClk,
  input  logic             rstN,
  input  logic [TAP_W-1:0] tapReq,
  output logic             divClk
);

  logic [TAP_W-1:0] tapMeta;
  logic [TAP_W-1:0] tapSync;
  logic [TAPS-1:0]  cnt;
  logic             tapBit;

  assign tapBit = (32'(tapSync) < TAPS) ? cnt[tapSync] : cnt[TAPS-1];

  // free-running counter; the output is a flop so a retap never glitches
  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      tapMeta <= '0;
      tapSync <= '0;
      cnt     <= '0;
      divClk  <= 1'b0;
    end else begin
      tapMeta <= tapReq;
      tapSync <= tapMeta;
      cnt     <= cnt + 1'b1;
      divClk  <= tapBit;
    end
  end

endmodule

// File: rtl/clksel_gfmux.sv
module clksel_gfmux #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] candClk,
  input  logic [N-1:0] reqVec,
  output logic         outClk
);

  logic [N-1:0] enVec;

  for (genvar i = 0; i < N; i++) begin : g_leg
    logic reqMeta;
    logic armQ;
    logic enQ;
    logic othersOn;

    assign othersOn = |(enVec & ~(N'(1) << i));

    // arm only once every other leg has let go
    always_ff @(posedge candClk[i] or negedge rstN) begin
      if (!rstN) begin
        reqMeta <= 1'b0;
        armQ    <= 1'b0;
      end else begin
        reqMeta <= reqVec[i];
        armQ    <= reqMeta & ~othersOn;
      end
    end

    // enable changes only while this clock is low
    always_ff @(negedge candClk[i] or negedge rstN) begin
      if (!rstN) enQ <= 1'b0;
      else       enQ <= armQ;
    end

    assign enVec[i] = enQ;
  end

  assign outClk = |(candClk & enVec);

  // R9: break-before-make across candidates
  p_en_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(enVec));

endmodule

// File: rtl/intclk_freq_sel.sv
module intclk_freq_sel
  import clksel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [3:0] wrSel,
  input  logic       wrPll,
  input  logic       cfgPllForce,
  input  logic [2:0] clkSrc,
  input  logic       hfClk,
  input  logic       mfClk,
  input  logic       lfClk,
  input  logic       pllClk,
  output logic       sysClk,
  output logic [1:0] activeSrc
);

  selCtl_t             ctl;
  logic                hfDiv;
  logic                mfDiv;
  logic [NUM_CAND-1:0] candClk;

  clksel_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrSel       (wrSel),
    .wrPll       (wrPll),
    .cfgPllForce (cfgPllForce),
    .clkSrc      (clkSrc),
    .ctl         (ctl)
  );

  clksel_postscaler #(.TAPS(HF_TAPS), .TAP_W(HF_TAP_W)) i_hfScale (
    .srcClk (hfClk),
    .rstN   (rstN),
    .tapReq (ctl.hfTap),
    .divClk (hfDiv)
  );

  clksel_postscaler #(.TAPS(MF_TAPS), .TAP_W(MF_TAP_W)) i_mfScale (
    .srcClk (mfClk),
    .rstN   (rstN),
    .tapReq (ctl.mfTap),
    .divClk (mfDiv)
  );

  always_comb begin
    candClk           = '0;
    candClk[C_LF]     = lfClk;
    candClk[C_MF_RAW] = mfClk;
    candClk[C_MF_DIV] = mfDiv;
    candClk[C_HF_RAW] = hfClk;
    candClk[C_HF_DIV] = hfDiv;
    candClk[C_PLL]    = pllClk;
  end

  clksel_gfmux #(.N(NUM_CAND)) i_switch (
    .clk     (clk),
    .rstN    (rstN),
    .candClk (candClk),
    .reqVec  (ctl.pick),
    .outClk  (sysClk)
  );

  assign activeSrc = ctl.srcId;

endmodule

// File: tb/test_intclk_freq_sel.sv
`timescale 1ns/1ps
module test_intclk_freq_sel;

  logic       clk = 1'b0;
  logic       rstN;
  logic       wrEn = 1'b0;
  logic [3:0] wrSel = 4'b0000;
  logic       wrPll = 1'b0;
  logic       cfgPllForce = 1'b0;
  logic [2:0] clkSrc = 3'b100;
  logic       hfClk = 1'b0;
  logic       mfClk = 1'b0;
  logic       lfClk = 1'b0;
  logic       pllClk = 1'b0;
  logic       sysClk;
  logic [1:0] activeSrc;

  int nChecks = 0;
  int nFail   = 0;

  localparam real HF_PER  = 62.5;
  localparam real MF_PER  = 2000.0;
  localparam real LF_PER  = 32258.06;
  localparam real PLL_PER = 31.25;

  intclk_freq_sel i_intclk_freq_sel (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrPll(wrPll),
    .cfgPllForce(cfgPllForce), .clkSrc(clkSrc), .hfClk(hfClk), .mfClk(mfClk),
    .lfClk(lfClk), .pllClk(pllClk), .sysClk(sysClk), .activeSrc(activeSrc)
  );

  always #2.5 clk = ~clk;
  always #(HF_PER/2.0) hfClk = ~hfClk;
  always #(MF_PER/2.0) mfClk = ~mfClk;
  always #(LF_PER/2.0) lfClk = ~lfClk;
  always #(PLL_PER/2.0) pllClk = ~pllClk;

  task automatic write_sel(input logic [3:0] code, input logic pll);
    @(negedge clk);
    wrSel = code;
    wrPll = pll;
    wrEn  = 1'b1;
    @(negedge clk);
    wrEn  = 1'b0;
  endtask

  // wait, then measure one output period and the source report
  task automatic expect_clk(input string tag, input real expPer,
                            input logic [1:0] expSrc, input real settleNs);
    realtime t0;
    real per;
    real diff;
    #(settleNs);
    @(posedge sysClk);
    t0 = $realtime;
    @(posedge sysClk);
    per = $realtime - t0;
    #1;
    diff = (per > expPer) ? per - expPer : expPer - per;
    nChecks++;
    if (diff > expPer * 0.01 + 0.05) begin
      nFail++;
      $display("FAIL %s period actual %0.3f ns expected %0.3f ns", tag, per, expPer);
    end
    nChecks++;
    if (activeSrc !== expSrc) begin
      nFail++;
      $display("FAIL %s activeSrc actual %b expected %b", tag, activeSrc, expSrc);
    end
  endtask

  task automatic t_reset;
    expect_clk("R1 reset 500k", MF_PER, 2'b01, 20000.0);
  endtask

  task automatic t_hf_raw;
    write_sel(4'b1111, 1'b0);
    expect_clk("R2 16M", HF_PER, 2'b10, 8000.0);
  endtask

  task automatic t_hf_div;
    write_sel(4'b1110, 1'b0);
    expect_clk("R3 8M", HF_PER * 2.0, 2'b10, 2000.0);
    write_sel(4'b1100, 1'b0);
    expect_clk("R3 2M", HF_PER * 8.0, 2'b10, 2000.0);
    write_sel(4'b1000, 1'b0);
    expect_clk("R3 125k", HF_PER * 128.0, 2'b10, 17000.0);
  endtask

  task automatic t_mf;
    write_sel(4'b0111, 1'b0);
    expect_clk("R4 500k", MF_PER, 2'b01, 31000.0);
    write_sel(4'b0110, 1'b0);
    expect_clk("R4 250k", MF_PER * 2.0, 2'b01, 19000.0);
    write_sel(4'b0100, 1'b0);
    expect_clk("R4 62.5k", MF_PER * 8.0, 2'b01, 33000.0);
    write_sel(4'b0011, 1'b0);
    expect_clk("R4 31.25k", MF_PER * 16.0, 2'b01, 65000.0);
    write_sel(4'b0010, 1'b0);
    expect_clk("R4 dup 31.25k", MF_PER * 16.0, 2'b01, 10000.0);
  endtask

  task automatic t_pll_gate;
    clkSrc = 3'b000;
    write_sel(4'b1110, 1'b1);
    expect_clk("R8 src blocks mult", HF_PER * 2.0, 2'b10, 100000.0);
    clkSrc = 3'b100;
    expect_clk("R6 32M", PLL_PER, 2'b11, 2000.0);
    write_sel(4'b1110, 1'b0);
    expect_clk("R8 sw bit clear", HF_PER * 2.0, 2'b10, 2000.0);
  endtask

  task automatic t_force;
    cfgPllForce = 1'b1;
    expect_clk("R7 force 32M", PLL_PER, 2'b11, 2000.0);
    write_sel(4'b1111, 1'b0);
    expect_clk("R7 force other code", HF_PER, 2'b10, 2000.0);
    cfgPllForce = 1'b0;
  endtask

  task automatic t_no_write;
    write_sel(4'b1110, 1'b0);
    expect_clk("R10 setup 8M", HF_PER * 2.0, 2'b10, 2000.0);
    @(negedge clk);
    wrSel = 4'b0000;
    wrPll = 1'b1;
    repeat (20) @(negedge clk);
    expect_clk("R10 ignored data", HF_PER * 2.0, 2'b10, 2000.0);
  endtask

  task automatic t_lf;
    write_sel(4'b0001, 1'b0);
    expect_clk("R5 31k code1", LF_PER, 2'b00, 98000.0);
    write_sel(4'b0000, 1'b0);
    expect_clk("R5 31k code0", LF_PER, 2'b00, 5000.0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    repeat (20) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_hf_raw();
    t_hf_div();
    t_mf();
    t_pll_gate();
    t_force();
    t_no_write();
    t_lf();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule